// File: doc/BRIEF.md
# 64-bit Interval Timer with Split 32-bit Registers

This peripheral keeps a 64-bit up-counter and a 64-bit compare value. Each is reached through two 32-bit registers on a plain word-addressed register bus. A 4-bit prescaler divides the clock, and the counter advances once per prescaled tick. When the count equals the programmed limit on a tick, an interrupt status flag is set and the level interrupt output goes high. In continuous mode the counter then clears and keeps running. In one-shot mode it clears and halts until software issues another start command.

Writes to the limit registers go to program registers. A start command copies them into the active compare value. An optional fast-reload mode changes this: a write to the low limit half while the timer runs loads the new 64-bit value at once and restarts the count from zero. Reading the status register clears the interrupt. Reading the low count half captures the high half, so the high half can then be read as part of the same snapshot.

Top module: `tmr64_core`

## Requirements
- R1: After reset every readable register returns 0, the counter is halted and `irq` is low.
- R2: Register word index (`bus_addr`): 0 control, 1 mode, 2 limit low, 3 limit high, 4 count low, 5 count high, 6 status. Mode fields are bit 0 one-shot, bit 1 fast-reload and bits 11:8 divider. The limit and mode registers read back what was written. The control register reads 0.
- R3: Writing the control register with bit 0 set clears the count and prescaler, loads {limit high, limit low} as the active compare value and starts counting. Doing this while already running restarts the timer.
- R4: With divider value d, the counter advances once every d+1 clock cycles. A limit P therefore first matches (P+1)·(d+1) clock edges after the start edge.
- R5: A match occurs on a tick where the count equals the active compare value. It sets status bit 0, and `irq` follows that bit.
- R6: In continuous mode (mode bit 0 = 0) a match clears the count to zero and counting goes on, so matches repeat every P+1 ticks.
- R7: In one-shot mode (mode bit 0 = 1) a match clears the count and halts it. The count then stays at zero until the next start command.
- R8: With fast-reload (mode bit 1 = 1) a write to the limit low register while running makes {limit high, written value} the active compare value and restarts the count from zero.
- R9: With fast-reload off, limit writes do not change the active compare value of a running timer. They take effect at the next start command.
- R10: A read of the status register clears status bit 0, unless a match happens in the same cycle, in which case the bit stays set.
- R11: A read of count low returns the current low 32 bits and captures the high 32 bits. A following read of count high returns the captured value.
- R12: The compare covers all 64 bits: a nonzero limit high half prevents a match when only the low halves agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Level interrupt, high while status bit 0 is set |

## Verification
The hardest case to reach is a status read landing on the very edge where a new match occurs. The bench arranges it by running continuous mode with a zero limit and no division, so every tick matches and the clearing read cannot avoid a match. Another hard case is the fast-reload restart, because it only shows in when the next interrupt arrives. The bench times a low-half write into a long period and checks that the interrupt arrives exactly four ticks later. The sequence is repeated with fast-reload off to show the old period still governs.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;
  localparam int unsigned IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_MODE   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_LIM_LO = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LIM_HI = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CNT_LO = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CNT_HI = 3'd5;
  localparam logic [IDX_W-1:0] IDX_STAT   = 3'd6;

  localparam int unsigned MODE_ONESHOT_BIT = 0;
  localparam int unsigned MODE_RELOAD_BIT  = 1;
  localparam int unsigned MODE_DIV_LSB     = 8;
  localparam int unsigned CTRL_START_BIT   = 0;
endpackage

// File: rtl/tmr64_prescaler.sv
module tmr64_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  assign tick = run && (pre_q == div);

  always_comb begin
    pre_d = pre_q;
    if (clr || !run)   pre_d = '0;
    else if (tick)     pre_d = '0;
    else               pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr64_counter.sv
module tmr64_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  input  logic             oneshot,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic             run_q, run_d;

  assign match   = tick && !ld_en && (cnt_q == lim_q);
  assign cnt     = cnt_q;
  assign running = run_q;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    run_d = run_q;
    if (ld_en) begin
      cnt_d = '0;
      lim_d = ld_val;
      run_d = 1'b1;
    end else if (match) begin
      cnt_d = '0;
      run_d = !oneshot;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/tmr64_regfile.sv
module tmr64_regfile
  import tmr64_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 4,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  logic              match,
  output logic              ld_en,
  output logic [CNT_W-1:0]  ld_val,
  output logic              oneshot,
  output logic [PRE_W-1:0]  div,
  output logic              irq
);
  logic [DATA_W-1:0] lim_lo_q, lim_lo_d, lim_hi_q, lim_hi_d, shadow_q, shadow_d;
  logic              oneshot_q, oneshot_d, reload_q, reload_d, pend_q, pend_d;
  logic [PRE_W-1:0]  div_q, div_d;
  logic              wr, rd, start_cmd, fast_ld;
  logic [DATA_W-1:0] mode_rd;

  assign wr        = bus_en && bus_we;
  assign rd        = bus_en && !bus_we;
  assign start_cmd = wr && (bus_addr == IDX_CTRL) && bus_wdata[CTRL_START_BIT];
  assign fast_ld   = wr && (bus_addr == IDX_LIM_LO) && reload_q && running;

  assign ld_en   = start_cmd || fast_ld;
  assign ld_val  = fast_ld ? {lim_hi_q, bus_wdata} : {lim_hi_q, lim_lo_q};
  assign oneshot = oneshot_q;
  assign div     = div_q;
  assign irq     = pend_q;

  always_comb begin
    lim_lo_d  = lim_lo_q;
    lim_hi_d  = lim_hi_q;
    oneshot_d = oneshot_q;
    reload_d  = reload_q;
    div_d     = div_q;
    shadow_d  = shadow_q;
    if (wr && bus_addr == IDX_LIM_LO) lim_lo_d = bus_wdata;
    if (wr && bus_addr == IDX_LIM_HI) lim_hi_d = bus_wdata;
    if (wr && bus_addr == IDX_MODE) begin
      oneshot_d = bus_wdata[MODE_ONESHOT_BIT];
      reload_d  = bus_wdata[MODE_RELOAD_BIT];
      div_d     = bus_wdata[MODE_DIV_LSB +: PRE_W];
    end
    if (rd && bus_addr == IDX_CNT_LO) shadow_d = cnt[CNT_W-1:DATA_W];
    if (match)                             pend_d = 1'b1;
    else if (rd && bus_addr == IDX_STAT)   pend_d = 1'b0;
    else                                   pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_lo_q  <= '0;
      lim_hi_q  <= '0;
      oneshot_q <= 1'b0;
      reload_q  <= 1'b0;
      div_q     <= '0;
      shadow_q  <= '0;
      pend_q    <= 1'b0;
    end else begin
      lim_lo_q  <= lim_lo_d;
      lim_hi_q  <= lim_hi_d;
      oneshot_q <= oneshot_d;
      reload_q  <= reload_d;
      div_q     <= div_d;
      shadow_q  <= shadow_d;
      pend_q    <= pend_d;
    end
  end

  always_comb begin
    mode_rd                         = '0;
    mode_rd[MODE_ONESHOT_BIT]       = oneshot_q;
    mode_rd[MODE_RELOAD_BIT]        = reload_q;
    mode_rd[MODE_DIV_LSB +: PRE_W]  = div_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        IDX_MODE:   bus_rdata = mode_rd;
        IDX_LIM_LO: bus_rdata = lim_lo_q;
        IDX_LIM_HI: bus_rdata = lim_hi_q;
        IDX_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
        IDX_CNT_HI: bus_rdata = shadow_q;
        IDX_STAT:   bus_rdata = {{(DATA_W-1){1'b0}}, pend_q};
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr64_core.sv
module tmr64_core
  import tmr64_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 4,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             ld_en, tick, match, running, oneshot;
  logic [CNT_W-1:0] ld_val, cnt;
  logic [PRE_W-1:0] div;

  tmr64_regfile #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .running(running), .match(match),
    .ld_en(ld_en), .ld_val(ld_val), .oneshot(oneshot), .div(div), .irq(irq)
  );

  tmr64_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .clr(ld_en), .div(div), .tick(tick)
  );

  tmr64_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val), .tick(tick),
    .oneshot(oneshot), .cnt(cnt), .running(running), .match(match)
  );
endmodule

// File: rtl/tmr64_checker.sv
module tmr64_checker
  import tmr64_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [IDX_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              match,
  input logic              running,
  input logic              oneshot,
  input logic [CNT_W-1:0]  cnt
);
  logic stat_rd, start_wr;
  assign stat_rd  = bus_en && !bus_we && (bus_addr == IDX_STAT);
  assign start_wr = bus_en && bus_we && (bus_addr == IDX_CTRL) && bus_wdata[CTRL_START_BIT];

  p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (running && cnt == '0));

  p_match_raises_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq);

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt == '0));

  p_oneshot_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && oneshot && !start_wr) |=> !running);

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_wr) |=> $stable(cnt));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !match) |=> !irq);

  p_clear_loses_to_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && match) |=> irq);
endmodule

bind tmr64_core tmr64_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .match(match),
  .running(running), .oneshot(oneshot), .cnt(cnt)
);

// File: tb/tmr64_core_test.sv
module tmr64_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  tmr64_core uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: pops the expected read data when the read is on the bus.
  always @(negedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 unexpected read: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mode(input bit os, input bit fr, input int d);
    return (32'(d) << 8) | (32'(fr) << 1) | 32'(os);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk_irq(1'b0, "R1 reset");
    for (int i = 0; i < 7; i++) rd(3'(i), 32'h0, "R1 reset register");

    // R3 R5 R6 continuous, limit 5, no division
    wr(3'd2, 32'd5);
    wr(3'd1, mode(0, 0, 0));
    rd(3'd2, 32'd5, "R2 limit low readback");
    wr(3'd0, 32'h1);
    wait_cyc(5); chk_irq(1'b0, "R5 before match");
    wait_cyc(1); chk_irq(1'b1, "R5 match at edge 6");
    rd(3'd4, 32'd0, "R6 count wrapped to zero");
    rd(3'd6, 32'd1, "R5 status bit set");
    chk_irq(1'b0, "R10 cleared by read");
    wait_cyc(4); chk_irq(1'b1, "R6 second period");
    rd(3'd6, 32'd1, "R10 status before clear");
    chk_irq(1'b0, "R10 cleared again");

    // R7 one-shot
    wr(3'd1, mode(1, 0, 0));
    rd(3'd1, 32'h1, "R2 mode readback");
    wr(3'd0, 32'h1);
    wait_cyc(5); chk_irq(1'b0, "R7 before match");
    wait_cyc(1); chk_irq(1'b1, "R7 match");
    wait_cyc(10);
    rd(3'd4, 32'd0, "R7 count halted at zero");
    rd(3'd5, 32'd0, "R11 high half snapshot");
    chk_irq(1'b1, "R7 no further activity");
    rd(3'd6, 32'd1, "R7 status");
    chk_irq(1'b0, "R10 clear after one-shot");
    wr(3'd0, 32'h1);
    wait_cyc(6); chk_irq(1'b1, "R7 restart by start");
    rd(3'd6, 32'd1, "R7 status rerun");

    // R10 clearing read coincides with a match
    wr(3'd2, 32'd0);
    wr(3'd1, mode(0, 0, 0));
    wr(3'd0, 32'h1);
    wait_cyc(2); chk_irq(1'b1, "R10 matching every tick");
    rd(3'd6, 32'd1, "R10 status during match");
    chk_irq(1'b1, "R10 match wins over clear");
    wr(3'd1, mode(1, 0, 0));
    wait_cyc(2);
    rd(3'd6, 32'd1, "R10 status after halt");
    chk_irq(1'b0, "R10 cleared after halt");

    // R4 prescaler: limit 3, divider 2 -> match 12 edges after start
    wr(3'd2, 32'd3);
    wr(3'd1, mode(0, 0, 2));
    rd(3'd1, 32'h200, "R2 divider readback");
    wr(3'd0, 32'h1);
    wait_cyc(11); chk_irq(1'b0, "R4 before divided match");
    wait_cyc(1);  chk_irq(1'b1, "R4 divided match");
    wr(3'd1, mode(1, 0, 2));
    wait_cyc(12);
    rd(3'd6, 32'd1, "R4 status");
    chk_irq(1'b0, "R4 cleared");

    // R8 fast-reload on
    wr(3'd2, 32'd100);
    wr(3'd1, mode(0, 1, 0));
    wr(3'd0, 32'h1);
    wait_cyc(10);
    wr(3'd2, 32'd3);
    wait_cyc(3); chk_irq(1'b0, "R8 before reloaded match");
    wait_cyc(1); chk_irq(1'b1, "R8 reloaded match");
    rd(3'd2, 32'd3, "R8 limit low updated");
    wr(3'd1, mode(1, 1, 0));
    wait_cyc(6);
    rd(3'd6, 32'd1, "R8 status");
    chk_irq(1'b0, "R8 cleared");

    // R9 fast-reload off
    wr(3'd2, 32'd4);
    wr(3'd1, mode(0, 0, 0));
    wr(3'd0, 32'h1);
    wait_cyc(2);
    wr(3'd2, 32'd50);
    wait_cyc(1); chk_irq(1'b0, "R9 before match");
    wait_cyc(1); chk_irq(1'b1, "R9 old limit still active");
    rd(3'd2, 32'd50, "R9 program register holds new value");
    rd(3'd6, 32'd1, "R9 status");
    chk_irq(1'b0, "R9 cleared");
    wait_cyc(3); chk_irq(1'b1, "R9 second period uses old limit");
    wr(3'd1, mode(1, 0, 0));
    wait_cyc(6);
    rd(3'd6, 32'd1, "R9 status final");
    chk_irq(1'b0, "R9 cleared final");

    // R12 high half takes part in the compare; R11 snapshot
    wr(3'd3, 32'd1);
    wr(3'd2, 32'd5);
    wr(3'd1, mode(0, 0, 0));
    wr(3'd0, 32'h1);
    wait_cyc(8); chk_irq(1'b0, "R12 low halves equal, no match");
    rd(3'd3, 32'd1, "R12 limit high readback");
    rd(3'd4, 32'd9, "R11 count low");
    rd(3'd5, 32'd0, "R11 count high shadow");

    wait_cyc(2);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 pending reads: actual %0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule